// File: doc/BRIEF.md
# Nonvolatile Memory Write Guard

This block decides whether each access to the program and data nonvolatile memories may proceed. After reset every write is refused. Software opens program memory and data memory separately by writing a two-byte key pair to a key port. The pair is written in one order for program memory and in the opposite order for data memory. A wrong byte bars that memory until the next reset. A relock input closes an open memory again without a reset.

Even when program memory is open, a boot-code region at the bottom of program memory stays closed. Its size is an option input counted in 512-byte pages, and application software cannot change it. A read-out protection flag blocks every debug-port access. Any attempt to change that flag while it is set raises a one-cycle mass-erase request. A sticky flag records each refused write.

Each memory has its own key state machine with four states: LOCKED, HALF (first key accepted), OPEN and BARRED. The transitions are:

- KEY_FIRST_OK: LOCKED to HALF.
- KEY_SECOND_OK: HALF to OPEN.
- KEY_BAD: LOCKED or HALF to BARRED.
- RELOCK: HALF or OPEN to LOCKED.

BARRED is left only by reset. A key write in OPEN or BARRED leaves the state unchanged.

Top module: `nvm_wr_guard`

## Requirements
- R1: After reset both memories are LOCKED, `acc_allow` refuses every write, and `illegal_wr` and `erase_req` are 0.
- R2: A key write with `key_sel`=0 and data 0x56, followed by a key write with `key_sel`=0 and data 0xAE, opens program memory from the cycle after the second write. Further key writes to an open memory change nothing.
- R3: A key write with `key_sel`=1 and data 0xAE, followed by one with data 0x56, opens data memory. The two memories keep independent states.
- R4: A key byte that does not match the expected one, in LOCKED or HALF, bars that memory. Later correct keys then leave it refused until reset.
- R5: `relock_prog` or `relock_data` returns HALF or OPEN to LOCKED on the next edge. A relock wins over a key write in the same cycle. A barred memory stays barred.
- R6: A program write (`acc_space`=0) whose offset is below `boot_pages`×512 is refused even when program memory is OPEN. The boundary page itself is writable. With `boot_pages` of 128 or more, the whole 64 KB is protected.
- R7: A data write (`acc_space`=1) is allowed only while data memory is OPEN.
- R8: Reads (`acc_write`=0) are allowed whenever no debug restriction applies.
- R9: While `rop_active`=1, any access with `acc_dbg`=1 is refused, read or write, whatever the key state.
- R10: `erase_req` is a one-cycle pulse in the cycle after `rop_wr`=1 with `rop_active`=1. `rop_wr` with `rop_active`=0 gives no pulse.
- R11: `illegal_wr` is set in the cycle after a refused write with `acc_valid`=1 and stays set until reset. Refused reads do not set it.
- R12: With `acc_valid`=0, `acc_allow` is 0 and nothing is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| key_wr | input | 1 | Key register write strobe |
| key_sel | input | 1 | Key target: 0 program, 1 data |
| key_data | input | 8 | Key byte |
| relock_prog | input | 1 | Return program memory to LOCKED |
| relock_data | input | 1 | Return data memory to LOCKED |
| boot_pages | input | 8 | Boot-code region size in 512-byte pages |
| acc_valid | input | 1 | Access request present |
| acc_write | input | 1 | 1 write, 0 read |
| acc_dbg | input | 1 | Access comes from the debug/programming port |
| acc_space | input | 1 | 0 program memory, 1 data memory |
| acc_addr | input | 16 | Byte offset within the addressed memory |
| rop_active | input | 1 | Read-out protection flag |
| rop_wr | input | 1 | Attempt to change the read-out protection flag |
| acc_allow | output | 1 | Current access may proceed (same cycle) |
| erase_req | output | 1 | Mass-erase request pulse |
| illegal_wr | output | 1 | Sticky refused-write flag |

## Verification
A key state machine stuck in the wrong state appears at `acc_allow` on the first write to that memory after the faulty key or relock cycle. The same fault shows in `illegal_wr` one edge later. An off-by-one boot boundary shows only on the last boot page or the first page above it, so both are driven. Mixed key orders, the relock-against-key race and the barred state are each followed by a write that exposes the resulting state at the ports.

// File: rtl/nvmg_pkg.sv
package nvmg_pkg;
    typedef enum logic [1:0] {
        KS_LOCKED,
        KS_HALF,
        KS_OPEN,
        KS_BARRED
    } key_state_t;

    localparam logic [7:0] KEY_A = 8'h56;
    localparam logic [7:0] KEY_B = 8'hAE;
    localparam int NUM_MEM = 2;
endpackage

// File: rtl/nvmg_key_fsm.sv
module nvmg_key_fsm
    import nvmg_pkg::*;
#(
    parameter logic [7:0] FIRST_KEY  = KEY_A,
    parameter logic [7:0] SECOND_KEY = KEY_B
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       key_wr,
    input  logic [7:0] key_data,
    input  logic       relock,
    output logic       unlocked
);
    key_state_t state, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= KS_LOCKED;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        if (relock) begin
            if (state != KS_BARRED) nxt = KS_LOCKED;           // RELOCK
        end else if (key_wr) begin
            unique case (state)
                KS_LOCKED: nxt = (key_data == FIRST_KEY)  ? KS_HALF : KS_BARRED;
                KS_HALF:   nxt = (key_data == SECOND_KEY) ? KS_OPEN : KS_BARRED;
                KS_OPEN:   nxt = KS_OPEN;
                KS_BARRED: nxt = KS_BARRED;
            endcase
        end
    end

    always_comb unlocked = (state == KS_OPEN);

    a_r2_open_needs_second_key: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> ($past(key_wr) && $past(key_data) == SECOND_KEY && !$past(relock)));
    a_r4_barred_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state == KS_BARRED) |=> (state == KS_BARRED));
    a_r5_relock_closes: assert property (@(posedge clk) disable iff (!rst_n)
        relock |=> !unlocked);
endmodule

// File: rtl/nvmg_access_check.sv
module nvmg_access_check #(
    parameter int ADDR_W     = 16,
    parameter int PAGE_SHIFT = 9
) (
    input  logic                         acc_valid,
    input  logic                         acc_write,
    input  logic                         acc_dbg,
    input  logic                         acc_space,
    input  logic [ADDR_W-1:0]            acc_addr,
    input  logic [ADDR_W-PAGE_SHIFT:0]   boot_pages,
    input  logic                         rop_active,
    input  logic [1:0]                   unlocked,
    output logic                         allow,
    output logic                         in_boot
);
    localparam int PAGE_W = ADDR_W - PAGE_SHIFT;
    localparam int BW     = PAGE_W + 1 + PAGE_SHIFT;

    logic [BW-1:0] boot_bytes;
    logic [BW-1:0] addr_ext;

    always_comb begin
        boot_bytes = {boot_pages, {PAGE_SHIFT{1'b0}}};
        addr_ext   = {{(BW-ADDR_W){1'b0}}, acc_addr};
        in_boot    = (addr_ext < boot_bytes);
        allow      = 1'b0;
        if (acc_valid && !(acc_dbg && rop_active)) begin
            if (!acc_write)     allow = 1'b1;
            else if (acc_space) allow = unlocked[1];
            else                allow = unlocked[0] && !in_boot;
        end
    end
endmodule

// File: rtl/nvm_wr_guard.sv
module nvm_wr_guard
    import nvmg_pkg::*;
#(
    parameter int PROG_BYTES = 65536,
    parameter int PAGE_BYTES = 512
) (
    input  logic                                              clk,
    input  logic                                              rst_n,
    input  logic                                              key_wr,
    input  logic                                              key_sel,
    input  logic [7:0]                                        key_data,
    input  logic                                              relock_prog,
    input  logic                                              relock_data,
    input  logic [$clog2(PROG_BYTES)-$clog2(PAGE_BYTES):0]    boot_pages,
    input  logic                                              acc_valid,
    input  logic                                              acc_write,
    input  logic                                              acc_dbg,
    input  logic                                              acc_space,
    input  logic [$clog2(PROG_BYTES)-1:0]                     acc_addr,
    input  logic                                              rop_active,
    input  logic                                              rop_wr,
    output logic                                              acc_allow,
    output logic                                              erase_req,
    output logic                                              illegal_wr
);
    localparam int ADDR_W     = $clog2(PROG_BYTES);
    localparam int PAGE_SHIFT = $clog2(PAGE_BYTES);

    logic [NUM_MEM-1:0] unlocked;
    logic [NUM_MEM-1:0] relock_v;
    logic               in_boot;

    always_comb relock_v = {relock_data, relock_prog};

    for (genvar m = 0; m < NUM_MEM; m++) begin : g_key
        nvmg_key_fsm #(
            .FIRST_KEY  ((m == 0) ? KEY_A : KEY_B),
            .SECOND_KEY ((m == 0) ? KEY_B : KEY_A)
        ) u_fsm (
            .clk      (clk),
            .rst_n    (rst_n),
            .key_wr   (key_wr && (key_sel == m[0])),
            .key_data (key_data),
            .relock   (relock_v[m]),
            .unlocked (unlocked[m])
        );
    end

    nvmg_access_check #(
        .ADDR_W     (ADDR_W),
        .PAGE_SHIFT (PAGE_SHIFT)
    ) u_chk (
        .acc_valid  (acc_valid),
        .acc_write  (acc_write),
        .acc_dbg    (acc_dbg),
        .acc_space  (acc_space),
        .acc_addr   (acc_addr),
        .boot_pages (boot_pages),
        .rop_active (rop_active),
        .unlocked   (unlocked),
        .allow      (acc_allow),
        .in_boot    (in_boot)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            erase_req  <= 1'b0;
            illegal_wr <= 1'b0;
        end else begin
            erase_req  <= rop_wr && rop_active;
            illegal_wr <= illegal_wr || (acc_valid && acc_write && !acc_allow);
        end
    end

    a_r6_boot_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && !acc_space && in_boot) |-> !acc_allow);
    a_r9_rop_blocks_debug: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_dbg && rop_active) |-> !acc_allow);
    a_r10_erase_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (rop_wr && rop_active) |=> erase_req);
    a_r11_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_wr |=> illegal_wr);
    a_r12_idle_refused: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |-> !acc_allow);
endmodule

// File: tb/nvm_wr_guard_tb.sv
module nvm_wr_guard_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        key_wr = 0, key_sel = 0, relock_prog = 0, relock_data = 0;
    logic [7:0]  key_data = 0;
    logic [7:0]  boot_pages = 0;
    logic        acc_valid = 0, acc_write = 0, acc_dbg = 0, acc_space = 0;
    logic [15:0] acc_addr = 0;
    logic        rop_active = 0, rop_wr = 0;
    logic        acc_allow, erase_req, illegal_wr;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // reference model: 0 locked, 1 half, 2 open, 3 barred
    int st[2];
    bit m_illegal, m_erase;

    always #(CLK_PERIOD/2) clk = ~clk;

    nvm_wr_guard u_dut (
        .clk(clk), .rst_n(rst_n), .key_wr(key_wr), .key_sel(key_sel), .key_data(key_data),
        .relock_prog(relock_prog), .relock_data(relock_data), .boot_pages(boot_pages),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_dbg(acc_dbg), .acc_space(acc_space),
        .acc_addr(acc_addr), .rop_active(rop_active), .rop_wr(rop_wr),
        .acc_allow(acc_allow), .erase_req(erase_req), .illegal_wr(illegal_wr)
    );

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0b exp=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input string note);
        bit e;
        string tag;
        int fk, sk;
        #1;
        e = 0; tag = "R12";
        if (acc_valid) begin
            if (acc_dbg && rop_active) begin e = 0; tag = "R9"; end
            else if (!acc_write) begin e = 1; tag = "R8"; end
            else if (acc_space) begin e = (st[1] == 2); tag = (st[1] == 3) ? "R4" : "R7"; end
            else if (st[0] != 2) begin e = 0; tag = (st[0] == 3) ? "R4" : "R2"; end
            else if (int'(acc_addr) < int'(boot_pages) * 512) begin e = 0; tag = "R6"; end
            else begin e = 1; tag = "R6"; end
        end
        chk(acc_allow, e, {tag, " ", note});
        @(posedge clk);
        m_erase = rop_wr && rop_active;
        if (acc_valid && acc_write && !e) m_illegal = 1;
        for (int m = 0; m < 2; m++) begin
            fk = (m == 0) ? 8'h56 : 8'hAE;
            sk = (m == 0) ? 8'hAE : 8'h56;
            if ((m == 0 && relock_prog) || (m == 1 && relock_data)) begin
                if (st[m] != 3) st[m] = 0;
            end else if (key_wr && key_sel == m[0]) begin
                if (st[m] == 0) st[m] = (int'(key_data) == fk) ? 1 : 3;
                else if (st[m] == 1) st[m] = (int'(key_data) == sk) ? 2 : 3;
            end
        end
        @(negedge clk);
        chk(illegal_wr, m_illegal, {"R11 ", note});
        chk(erase_req, m_erase, {"R10 ", note});
        key_wr = 0; relock_prog = 0; relock_data = 0; acc_valid = 0; acc_write = 0;
        acc_dbg = 0; rop_wr = 0;
    endtask

    task automatic do_reset();
        rst_n = 0;
        @(negedge clk); @(negedge clk);
        st[0] = 0; st[1] = 0; m_illegal = 0; m_erase = 0;
        chk(illegal_wr, 1'b0, "R1 reset flag");
        chk(erase_req, 1'b0, "R1 reset erase");
        rst_n = 1;
    endtask

    task automatic key(input logic sel, input logic [7:0] d, input string note);
        key_wr = 1; key_sel = sel; key_data = d; step(note);
    endtask

    task automatic acc(input logic w, input logic dbg, input logic sp, input logic [15:0] a,
                       input string note);
        acc_valid = 1; acc_write = w; acc_dbg = dbg; acc_space = sp; acc_addr = a; step(note);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        boot_pages = 8'd4;
        do_reset();
        acc(1, 0, 0, 16'h8000, "R1 locked prog write");
        acc(1, 0, 1, 16'h0010, "R1 locked data write");
        // R2 program unlock
        key(0, 8'h56, "R2 first key");
        acc(1, 0, 0, 16'h8000, "R2 half state still refused");
        key(0, 8'hAE, "R2 second key");
        acc(1, 0, 0, 16'h8000, "R2 open prog write");
        key(0, 8'h12, "R2 key in open ignored");
        acc(1, 0, 0, 16'h0100, "R6 boot page 0");
        acc(1, 0, 0, 16'h07FF, "R6 last boot byte");
        acc(1, 0, 0, 16'h0800, "R6 first page above boot");
        acc(1, 0, 1, 16'h0000, "R7 data still locked");
        // R3 data unlock with opposite order
        key(1, 8'hAE, "R3 data first key");
        key(1, 8'h56, "R3 data second key");
        acc(1, 0, 1, 16'h007F, "R3 data open");
        acc(1, 0, 0, 16'hFFFF, "R3 prog still open");
        // R5 relock
        relock_prog = 1; step("R5 relock prog");
        acc(1, 0, 0, 16'h8000, "R5 prog relocked");
        acc(1, 0, 1, 16'h0001, "R5 data unaffected");
        key(0, 8'h56, "R5 first key again");
        relock_prog = 1; key(0, 8'hAE, "R5 relock beats key");
        acc(1, 0, 0, 16'h8000, "R5 still locked");
        // R4 wrong key bars
        key(0, 8'h00, "R4 wrong first key");
        key(0, 8'h56, "R4 key after bar");
        key(0, 8'hAE, "R4 key after bar 2");
        acc(1, 0, 0, 16'h8000, "R4 barred write");
        relock_prog = 1; step("R4 relock on barred");
        key(0, 8'h56, "R4 retry");
        key(0, 8'hAE, "R4 retry 2");
        acc(1, 0, 0, 16'h8000, "R4 still barred");
        // R8 / R9 reads and debug
        acc(0, 0, 0, 16'h1234, "R8 plain read");
        acc(0, 1, 1, 16'h0004, "R8 debug read rop off");
        rop_active = 1;
        acc(0, 1, 0, 16'h1234, "R9 debug read rop on");
        acc(1, 1, 1, 16'h0004, "R9 debug write rop on");
        acc(0, 0, 0, 16'h1234, "R8 cpu read rop on");
        acc(1, 0, 1, 16'h0004, "R7 cpu data write rop on");
        // R10 erase
        rop_wr = 1; step("R10 change attempt");
        step("R10 pulse ends");
        rop_active = 0;
        rop_wr = 1; step("R10 no erase when off");
        // second life
        do_reset();
        acc_write = 1; acc_valid = 0; step("R12 invalid write");
        chk(illegal_wr, 1'b0, "R12 nothing flagged");
        key(0, 8'h56, "R2 k1");
        key(0, 8'hAE, "R2 k2");
        boot_pages = 8'd0;
        acc(1, 0, 0, 16'h0000, "R6 no boot region");
        boot_pages = 8'd128;
        acc(1, 0, 0, 16'hFFFF, "R6 full boot region");
        boot_pages = 8'd200;
        acc(1, 0, 0, 16'hFFFF, "R6 oversize boot region");
        boot_pages = 8'd1;
        acc(1, 0, 0, 16'h0200, "R6 one page boundary");
        key(1, 8'h56, "R4 data wrong first");
        key(1, 8'h56, "R4 data key after bar");
        acc(1, 0, 1, 16'h0000, "R4 data barred");
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule